// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block produces the serial clock of a two-wire bus controller from the system clock. A byte engine beside it starts and stops the clock with a run input. The engine uses two one-cycle strobes that come out of the generator. One marks the safe point in the low half-bit for changing the data line. The other marks the point in the high half-bit for sampling it. The clock pin is open drain: the generator only asserts a pull-low enable, and it watches the wire level. This lets it honour a target that holds the clock low.

Three timing shapes are selectable. Standard speed has equal low and high phases of one period count each. Fast speed has a low:high ratio of 2:1, or 16:9 when the duty flag is set. A rise-time count gives the wire time to rise after release before a low level is treated as clock stretching.

A combinational helper, independent of the generator, derives the settings from the clock frequency in MHz and a target rate in kHz. It returns the period count, the speed mode, the duty choice and the rise-time count.

Top module: `i2c_scl_timer`

## Requirements
- R1: While reset is asserted or `run_en` is low, `scl_drive_low`, `sda_change_stb` and `sda_sample_stb` are all 0. One cycle after `run_en` falls, `scl_drive_low` is 0.
- R2: With `cfg_fast`=0, each low phase and each unstretched high phase lasts exactly P system clocks, where P is the period count. `cfg_duty169` has no effect in this mode.
- R3: With `cfg_fast`=1 and `cfg_duty169`=0, the low phase lasts 2P clocks and the unstretched high phase lasts P clocks.
- R4: With `cfg_fast`=1 and `cfg_duty169`=1, the low phase lasts 16P clocks and the unstretched high phase lasts 9P clocks.
- R5: `sda_change_stb` pulses exactly once per low phase. It falls in low-phase cycle floor(L/2), counting the first low cycle as 0, where L is the low length.
- R6: `sda_sample_stb` pulses exactly once per high phase, only while the clock is released. With no stretching it falls in high-phase cycle floor(H/2), where H is the high length.
- R7: After release, the high-phase count advances for the first `cfg_rise` cycles even if `scl_in` is low. After that it advances only while `scl_in` is high. A target holding the clock low for S cycles lengthens the released phase to H + max(0, S - `cfg_rise`) clocks.
- R8: A period count of 0 behaves as a period count of 1.
- R9: For targets of 100 kHz or below, the helper reports `calc_fast`=0 and `calc_duty169`=0. It reports a period of floor(F/(2R)), where F is the clock in kHz and R the target in kHz, raised to at least 4. Its rise count is MHz+1.
- R10: For targets above 100 kHz, the helper reports `calc_fast`=1 and computes two candidate counts.
  - Each candidate is c = floor(F/(uR)), with u=3 for 2:1 and u=25 for 16:9. It is incremented when zero or when floor(F/(uc)) > R.
  - The helper picks 2:1 (`calc_duty169`=0) only when its resulting rate is strictly higher than the 16:9 rate. Otherwise it picks 16:9.
  - Its rise count is floor(3·MHz/10)+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Runs the clock generator while high |
| cfg_period | input | 12 | Period count P |
| cfg_fast | input | 1 | 1 selects fast-speed shapes |
| cfg_duty169 | input | 1 | In fast speed, 1 selects 16:9, 0 selects 2:1 |
| cfg_rise | input | 6 | Rise-time allowance in clocks |
| scl_in | input | 1 | Sampled level of the clock wire |
| scl_drive_low | output | 1 | 1 pulls the clock wire low |
| sda_change_stb | output | 1 | Mid-low strobe for driving data |
| sda_sample_stb | output | 1 | Mid-high strobe for sampling data |
| calc_fclk_mhz | input | 6 | Helper: system clock in MHz |
| calc_rate_khz | input | 10 | Helper: target bit rate in kHz (0 treated as 1) |
| calc_period | output | 12 | Helper: derived period count |
| calc_fast | output | 1 | Helper: derived speed mode |
| calc_duty169 | output | 1 | Helper: derived duty choice |
| calc_rise | output | 6 | Helper: derived rise-time count |

## Verification
Two things can meet in one cycle: the end of the rise allowance, where clock stretching starts to freeze the high count, and the mid-high sample point. The bench holds the wire low past the allowance while the count is still short of its midpoint. It then checks three results: the released phase grows by exactly the held cycles beyond the allowance, one sample strobe still occurs, and that strobe lands at the midpoint shifted by the frozen cycles. A second stretch, shorter than the allowance, must leave both the length and the strobe position unchanged.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  localparam int unsigned STD_LIMIT_KHZ = 100;
  localparam int unsigned STD_MIN_COUNT = 4;
  localparam int unsigned UNITS_2TO1    = 3;
  localparam int unsigned UNITS_16TO9   = 25;

endpackage

// File: rtl/i2c_scl_rate_calc.sv
module i2c_scl_rate_calc
  import i2c_scl_pkg::*;
#(
  parameter int unsigned MHZ_W    = 6,
  parameter int unsigned RATE_W   = 10,
  parameter int unsigned PERIOD_W = 12,
  parameter int unsigned RISE_W   = 6
) (
  input  logic [MHZ_W-1:0]    fclk_mhz,
  input  logic [RATE_W-1:0]   rate_khz,
  output logic [PERIOD_W-1:0] period,
  output logic                fast,
  output logic                duty169,
  output logic [RISE_W-1:0]   rise
);

  localparam logic [31:0] PMAX = 32'((64'd1 << PERIOD_W) - 64'd1);
  localparam logic [31:0] RMAX = 32'((64'd1 << RISE_W) - 64'd1);

  logic [31:0] fk, r, c_std, b1, b2, c1, c2, q1, q2, v_per, v_rise;

  always_comb begin
    fk = 32'(fclk_mhz) * 32'd1000;
    r  = (rate_khz == '0) ? 32'd1 : 32'(rate_khz);

    c_std = fk / (32'd2 * r);
    if (c_std < 32'(STD_MIN_COUNT)) c_std = 32'(STD_MIN_COUNT);

    b1 = fk / (32'(UNITS_2TO1) * r);
    c1 = (b1 == '0) ? 32'd1 :
         ((fk / (b1 * 32'(UNITS_2TO1)) > r) ? b1 + 32'd1 : b1);
    b2 = fk / (32'(UNITS_16TO9) * r);
    c2 = (b2 == '0) ? 32'd1 :
         ((fk / (b2 * 32'(UNITS_16TO9)) > r) ? b2 + 32'd1 : b2);
    q1 = fk / (c1 * 32'(UNITS_2TO1));
    q2 = fk / (c2 * 32'(UNITS_16TO9));

    fast = (r > 32'(STD_LIMIT_KHZ));
    if (!fast) begin
      duty169 = 1'b0;
      v_per   = c_std;
      v_rise  = 32'(fclk_mhz) + 32'd1;
    end else begin
      duty169 = !(q1 > q2);
      v_per   = (q1 > q2) ? c1 : c2;
      v_rise  = (32'd3 * 32'(fclk_mhz)) / 32'd10 + 32'd1;
    end
    if (v_per > PMAX) v_per = PMAX;
    if (v_rise > RMAX) v_rise = RMAX;
    period = v_per[PERIOD_W-1:0];
    rise   = v_rise[RISE_W-1:0];
  end

endmodule

// File: rtl/i2c_scl_phase_len.sv
module i2c_scl_phase_len #(
  parameter int unsigned PERIOD_W = 12,
  parameter int unsigned LEN_W    = PERIOD_W + 4
) (
  input  logic [PERIOD_W-1:0] period,
  input  logic                fast,
  input  logic                duty169,
  output logic [LEN_W-1:0]    low_len,
  output logic [LEN_W-1:0]    high_len
);

  logic [LEN_W-1:0] p_eff;

  always_comb begin
    p_eff = (period == '0) ? LEN_W'(1) : LEN_W'(period);
    if (!fast) begin
      low_len  = p_eff;
      high_len = p_eff;
    end else if (!duty169) begin
      low_len  = p_eff << 1;
      high_len = p_eff;
    end else begin
      low_len  = p_eff << 4;
      high_len = (p_eff << 3) + p_eff;
    end
  end

endmodule

// File: rtl/i2c_scl_phase_gen.sv
module i2c_scl_phase_gen
  import i2c_scl_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned RISE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LEN_W-1:0]  low_len,
  input  logic [LEN_W-1:0]  high_len,
  input  logic [RISE_W-1:0] rise_len,
  input  logic              scl_in,
  output logic              drive_low,
  output logic              change_stb,
  output logic              sample_stb
);

  scl_phase_e        phase_q, phase_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [RISE_W-1:0] rise_q, rise_d;
  logic              rise_open, adv_hi, cnt_en, rise_en;

  assign rise_open = (rise_q < rise_len);
  assign adv_hi    = scl_in || rise_open;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    rise_d  = rise_q;
    if (!enable) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      rise_d  = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_LOW;
          cnt_d   = '0;
        end
        PH_LOW: begin
          if (cnt_q == low_len - LEN_W'(1)) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
            rise_d  = '0;
          end else begin
            cnt_d = cnt_q + LEN_W'(1);
          end
        end
        PH_HIGH: begin
          if (rise_open) rise_d = rise_q + RISE_W'(1);
          if (adv_hi) begin
            if (cnt_q == high_len - LEN_W'(1)) begin
              phase_d = PH_LOW;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + LEN_W'(1);
            end
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  assign cnt_en  = !enable || (phase_q != PH_HIGH) || adv_hi;
  assign rise_en = !enable || (phase_q != PH_HIGH) || rise_open ||
                   (phase_d != phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rise_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (rise_en) rise_q <= rise_d;
    end
  end

  assign drive_low  = (phase_q == PH_LOW);
  assign change_stb = (phase_q == PH_LOW) && (cnt_q == (low_len >> 1));
  assign sample_stb = (phase_q == PH_HIGH) && adv_hi &&
                      (cnt_q == (high_len >> 1));

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int unsigned PERIOD_W = 12,
  parameter int unsigned RISE_W   = 6,
  parameter int unsigned MHZ_W    = 6,
  parameter int unsigned RATE_W   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic                cfg_fast,
  input  logic                cfg_duty169,
  input  logic [RISE_W-1:0]   cfg_rise,
  input  logic                scl_in,
  output logic                scl_drive_low,
  output logic                sda_change_stb,
  output logic                sda_sample_stb,
  input  logic [MHZ_W-1:0]    calc_fclk_mhz,
  input  logic [RATE_W-1:0]   calc_rate_khz,
  output logic [PERIOD_W-1:0] calc_period,
  output logic                calc_fast,
  output logic                calc_duty169,
  output logic [RISE_W-1:0]   calc_rise
);

  localparam int unsigned LEN_W = PERIOD_W + 4;

  logic [LEN_W-1:0] low_len, high_len;

  i2c_scl_phase_len #(.PERIOD_W(PERIOD_W), .LEN_W(LEN_W)) u_len (
    .period   (cfg_period),
    .fast     (cfg_fast),
    .duty169  (cfg_duty169),
    .low_len  (low_len),
    .high_len (high_len)
  );

  i2c_scl_phase_gen #(.LEN_W(LEN_W), .RISE_W(RISE_W)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (run_en),
    .low_len    (low_len),
    .high_len   (high_len),
    .rise_len   (cfg_rise),
    .scl_in     (scl_in),
    .drive_low  (scl_drive_low),
    .change_stb (sda_change_stb),
    .sample_stb (sda_sample_stb)
  );

  i2c_scl_rate_calc #(
    .MHZ_W(MHZ_W), .RATE_W(RATE_W), .PERIOD_W(PERIOD_W), .RISE_W(RISE_W)
  ) u_calc (
    .fclk_mhz (calc_fclk_mhz),
    .rate_khz (calc_rate_khz),
    .period   (calc_period),
    .fast     (calc_fast),
    .duty169  (calc_duty169),
    .rise     (calc_rise)
  );

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk #(
  parameter int unsigned PERIOD_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run_en,
  input logic [PERIOD_W-1:0] cfg_period,
  input logic                cfg_fast,
  input logic                cfg_duty169,
  input logic                scl_drive_low,
  input logic                sda_change_stb,
  input logic                sda_sample_stb
);

  localparam int unsigned LEN_W = PERIOD_W + 4;

  logic [LEN_W:0]   low_run;
  logic [LEN_W-1:0] p_ref, exp_low;

  always_comb begin
    p_ref   = (cfg_period == '0) ? LEN_W'(1) : LEN_W'(cfg_period);
    exp_low = !cfg_fast ? p_ref : (cfg_duty169 ? LEN_W'(16) * p_ref
                                               : LEN_W'(2) * p_ref);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_run <= '0;
    else if (scl_drive_low) low_run <= low_run + 1'b1;
    else                    low_run <= '0;
  end

  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !scl_drive_low);

  // R2, R3 and R4: low phase length per mode
  assert_low_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_drive_low && $past(scl_drive_low) && run_en && $past(run_en))
    |-> (low_run == {1'b0, exp_low}));

  assert_change_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change_stb |-> scl_drive_low);

  assert_change_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change_stb |=> !sda_change_stb);

  assert_sample_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample_stb |-> (!scl_drive_low && !sda_change_stb));

endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .run_en         (run_en),
  .cfg_period     (cfg_period),
  .cfg_fast       (cfg_fast),
  .cfg_duty169    (cfg_duty169),
  .scl_drive_low  (scl_drive_low),
  .sda_change_stb (sda_change_stb),
  .sda_sample_stb (sda_sample_stb)
);

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {fast, duty169, period[11:0], exp_low[15:0], exp_high[15:0]}
  localparam logic [45:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 12'd5, 16'd5,  16'd5},   // R2
    {1'b0, 1'b0, 12'd1, 16'd1,  16'd1},   // R2
    {1'b0, 1'b0, 12'd0, 16'd1,  16'd1},   // R8
    {1'b0, 1'b1, 12'd6, 16'd6,  16'd6},   // R2 duty ignored
    {1'b1, 1'b0, 12'd4, 16'd8,  16'd4},   // R3
    {1'b1, 1'b0, 12'd3, 16'd6,  16'd3},   // R3
    {1'b1, 1'b1, 12'd1, 16'd16, 16'd9},   // R4
    {1'b1, 1'b1, 12'd2, 16'd32, 16'd18}   // R4
  };

  logic        clk, rst_n, run_en, cfg_fast, cfg_duty169, hold_low, scl_in;
  logic [11:0] cfg_period;
  logic [5:0]  cfg_rise;
  logic        scl_drive_low, sda_change_stb, sda_sample_stb;
  logic [5:0]  calc_fclk_mhz;
  logic [9:0]  calc_rate_khz;
  logic [11:0] calc_period;
  logic        calc_fast, calc_duty169;
  logic [5:0]  calc_rise;

  int checks = 0;
  int errors = 0;

  assign scl_in = !(scl_drive_low || hold_low);

  i2c_scl_timer u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .cfg_period(cfg_period), .cfg_fast(cfg_fast), .cfg_duty169(cfg_duty169),
    .cfg_rise(cfg_rise), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .sda_change_stb(sda_change_stb),
    .sda_sample_stb(sda_sample_stb),
    .calc_fclk_mhz(calc_fclk_mhz), .calc_rate_khz(calc_rate_khz),
    .calc_period(calc_period), .calc_fast(calc_fast),
    .calc_duty169(calc_duty169), .calc_rise(calc_rise)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = !clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int lo, output int hi, output int cpos,
                         output int cn, output int spos, output int sn);
    lo = 0; hi = 0; cpos = -1; cn = 0; spos = -1; sn = 0;
    while (scl_drive_low) @(negedge clk);
    while (!scl_drive_low) @(negedge clk);
    while (scl_drive_low) begin
      if (sda_change_stb) begin cn++; cpos = lo; end
      if (sda_sample_stb) sn++;
      lo++;
      @(negedge clk);
    end
    while (!scl_drive_low) begin
      if (sda_sample_stb) begin sn++; spos = hi; end
      if (sda_change_stb) cn++;
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic restart(input logic f, input logic d, input logic [11:0] p,
                         input logic [5:0] rs);
    run_en = 1'b0;
    repeat (2) @(negedge clk);
    cfg_fast = f; cfg_duty169 = d; cfg_period = p; cfg_rise = rs;
    run_en = 1'b1;
  endtask

  task automatic stretch(input int s, output int rel, output int sn, output int spos);
    int k;
    while (!scl_drive_low) @(negedge clk);
    while (scl_drive_low) @(negedge clk);
    hold_low = 1'b1;
    rel = 0; k = 0; sn = 0; spos = -1;
    while (!scl_drive_low) begin
      if (sda_sample_stb) begin sn++; spos = rel; end
      rel++;
      @(negedge clk);
      k++;
      if (k == s) hold_low = 1'b0;
    end
    hold_low = 1'b0;
  endtask

  task automatic calc_case(input int mhz, input int khz, input int ep,
                           input int ef, input int ed, input int er, input string req);
    @(negedge clk);
    calc_fclk_mhz = 6'(mhz);
    calc_rate_khz = 10'(khz);
    #1;
    chk(calc_period == 12'(ep), {req, " period"}, calc_period, ep);
    chk(calc_fast == 1'(ef), {req, " fast"}, calc_fast, ef);
    chk(calc_duty169 == 1'(ed), {req, " duty"}, calc_duty169, ed);
    chk(calc_rise == 6'(er), {req, " rise"}, calc_rise, er);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lo, hi, cpos, cn, spos, sn, rel;
    rst_n = 1'b0; run_en = 1'b0; hold_low = 1'b0;
    cfg_fast = 1'b0; cfg_duty169 = 1'b0; cfg_period = 12'd5; cfg_rise = 6'd0;
    calc_fclk_mhz = 6'd0; calc_rate_khz = 10'd100;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!scl_drive_low && !sda_change_stb && !sda_sample_stb,
        "R1 reset outputs", int'(scl_drive_low), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!scl_drive_low, "R1 idle released", int'(scl_drive_low), 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [45:0] v;
      int el, eh;
      v  = VEC[i];
      el = int'(v[31:16]);
      eh = int'(v[15:0]);
      restart(v[45], v[44], v[43:32], 6'd0);
      measure(lo, hi, cpos, cn, spos, sn);
      chk(lo == el, $sformatf("R2/R3/R4/R8 low length vec%0d", i), lo, el);
      chk(hi == eh, $sformatf("R2/R3/R4/R8 high length vec%0d", i), hi, eh);
      chk(cn == 1, $sformatf("R5 change count vec%0d", i), cn, 1);
      chk(cpos == el / 2, $sformatf("R5 change position vec%0d", i), cpos, el / 2);
      chk(sn == 1, $sformatf("R6 sample count vec%0d", i), sn, 1);
      chk(spos == eh / 2, $sformatf("R6 sample position vec%0d", i), spos, eh / 2);
    end

    // R7 stretch beyond allowance: 8 + (6-2) = 12, strobe shifted by 4
    restart(1'b0, 1'b0, 12'd8, 6'd2);
    stretch(6, rel, sn, spos);
    chk(rel == 12, "R7 stretched high length", rel, 12);
    chk(sn == 1, "R7 one sample strobe", sn, 1);
    chk(spos == 8, "R7 sample strobe deferred", spos, 8);
    // R7 stretch inside allowance: no extension
    stretch(1, rel, sn, spos);
    chk(rel == 8, "R7 short hold absorbed", rel, 8);
    chk(spos == 4, "R7 sample strobe unmoved", spos, 4);

    // R1 stop while low
    restart(1'b1, 1'b1, 12'd3, 6'd0);
    while (!scl_drive_low) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    chk(!scl_drive_low, "R1 stop releases", int'(scl_drive_low), 0);
    repeat (3) @(negedge clk);
    chk(!scl_drive_low && !sda_change_stb && !sda_sample_stb,
        "R1 stays idle", int'(scl_drive_low), 0);

    // helper
    calc_case(42, 100, 210, 0, 0, 43, "R9 42MHz 100k");
    calc_case(0,  50,  4,   0, 0, 1,  "R9 floor");
    calc_case(8,  100, 40,  0, 0, 9,  "R9 8MHz 100k");
    calc_case(42, 400, 35,  1, 0, 13, "R10 42MHz 400k");
    calc_case(10, 400, 1,   1, 1, 4,  "R10 10MHz 400k");
    calc_case(42, 300, 47,  1, 0, 13, "R10 42MHz 300k");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule